// File: doc/BRIEF.md
# Decorrelated LFSR Random Word Generator

This block produces pseudo-random words from a maximal-length linear feedback shift register. Each enabled clock moves the register one place toward its top bit and feeds a new bit in at the bottom. That bit is the XOR of a fixed set of tap bits near the top of the register. Two register snapshots taken one step apart share all but one bit. For that reason the block publishes a word only after the register has taken a full register-width of new steps since the last word, or since reset, or since a seed load. The word then comes out on a registered output together with a one-cycle valid strobe.

A client that needs random stimulus or dither values holds `en` high and takes `word_out` in every cycle in which `word_valid` is high. A seed port lets the client restart the sequence from a chosen value. The register can never be seeded to the all-zero state, because that state locks it up. This generator is not suitable for cryptographic use.

Top module: `rng_word_gen`

## Requirements
- R1: While `rst` is high, on a clock edge the register is set to the value 1 and the step count is set to zero. `word_valid` and `word_out` both go to zero.
- R2: On each enabled clock without a seed load, the register shifts one place toward the MSB. The new bit 0 is the XOR of bits 63, 62, 60 and 59 (0-indexed, default width 64).
- R3: `word_valid` is high for exactly one cycle. It rises after the clock edge that completes the WIDTH-th enabled step since the last word, the release of reset or the last seed load.
- R4: In the cycle in which `word_valid` is high, `word_out` equals the register value after that WIDTH-th step. `word_out` holds that value until the next word.
- R5: While `en` is low and `seed_load` is low, the register and the step count hold their values and no word is released.
- R6: When `seed_load` is high, the register takes `seed_val`, the step count restarts from zero and no word is released in that cycle. A seed load takes priority over `en`.
- R7: A seed load with `seed_val` equal to zero loads the value 1 instead.
- R8: The register never holds the all-zero value after reset, so every released word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register one step on this clock |
| seed_load | input | 1 | Load `seed_val` into the register and restart the step count |
| seed_val | input | WIDTH | Seed value; zero is replaced by 1 |
| word_out | output | WIDTH | Last released random word |
| word_valid | output | 1 | One-cycle strobe marking a new `word_out` |

## Verification
The bench keeps its own model of the shift sequence and predicts every word, so a wrong tap or a reversed shift direction shows up as a wrong `word_out`. Enable gaps and long idle stretches are aimed at a counter that keeps counting while disabled. Such a counter would release words too early, or release words with mismatched values. Seed loads arrive partway through a word, with `en` also high, and one carries a zero seed. A design that failed to restart the count, let the step win over the load, or took the zero seed as given would release early words, wrong words or all-zero words. Every check is timed to the registered output: a valid strobe one cycle late, or held for two cycles, fails at once.

// File: rtl/rng_pkg.sv
package rng_pkg;
  // Default register width and its primitive feedback taps (0-indexed bits 63,62,60,59)
  localparam int unsigned DEF_WIDTH = 64;
  localparam logic [63:0] DEF_TAPS  = 64'hD800_0000_0000_0000;
endpackage

// File: rtl/rng_shift_core.sv
module rng_shift_core #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] TAP_MASK = W'(64'hD800_0000_0000_0000)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         seed_load,
  input  logic [W-1:0] seed_val,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_step
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] tap_bits;
  logic         fb;
  logic [W-1:0] seed_fix;

  // Tap selection built per bit; a zero mask bit drops that position
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (TAP_MASK[i]) begin : g_on
      assign tap_bits[i] = state_q[i];
    end else begin : g_off
      assign tap_bits[i] = 1'b0;
    end
  end

  assign fb         = ^tap_bits;
  assign state_step = {state_q[W-2:0], fb};
  assign seed_fix   = (seed_val == '0) ? ONE : seed_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ONE;
    end else if (seed_load) begin
      state_q <= seed_fix;
    end else if (en) begin
      state_q <= state_step;
    end
  end
endmodule

// File: rtl/rng_step_ctr.sv
module rng_step_ctr #(
  parameter int unsigned W = 64,
  localparam int unsigned CW = (W > 2) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          seed_load,
  output logic [CW-1:0] cnt_q,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  assign wrap = en && !seed_load && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || seed_load) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= wrap ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/rng_word_reg.sv
module rng_word_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_q,
  output logic         valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
      if (capture) begin
        word_q <= word_in;
      end
    end
  end
endmodule

// File: rtl/rng_word_gen.sv
module rng_word_gen #(
  parameter int unsigned WIDTH = rng_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAP_MASK = WIDTH'(rng_pkg::DEF_TAPS),
  localparam int unsigned CW = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_val,
  output logic [WIDTH-1:0] word_out,
  output logic             word_valid
);
  logic [WIDTH-1:0] lfsr_q;
  logic [WIDTH-1:0] lfsr_step;
  logic [CW-1:0]    step_cnt;
  logic             word_due;

  rng_shift_core #(.W(WIDTH), .TAP_MASK(TAP_MASK)) u_core (
    .clk(clk), .rst(rst), .en(en), .seed_load(seed_load), .seed_val(seed_val),
    .state_q(lfsr_q), .state_step(lfsr_step)
  );

  rng_step_ctr #(.W(WIDTH)) u_ctr (
    .clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
    .cnt_q(step_cnt), .wrap(word_due)
  );

  rng_word_reg #(.W(WIDTH)) u_out (
    .clk(clk), .rst(rst), .capture(word_due), .word_in(lfsr_step),
    .word_q(word_out), .valid_q(word_valid)
  );
endmodule

// File: rtl/rng_word_gen_chk.sv
module rng_word_gen_chk #(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned CW = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             seed_load,
  input logic [WIDTH-1:0] seed_val,
  input logic [WIDTH-1:0] state,
  input logic [CW-1:0]    cnt,
  input logic [WIDTH-1:0] word_out,
  input logic             word_valid
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  // R8
  a_r8_state_nonzero: assert property (@(posedge clk) disable iff (rst || !armed)
    state != '0);

  // R2
  a_r2_shift_up: assert property (@(posedge clk) disable iff (rst || !armed)
    (en && !seed_load) |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));

  // R5
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    (!en && !seed_load) |=> ($stable(state) && $stable(cnt) && !word_valid));

  // R3
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst || !armed)
    word_valid |=> !word_valid);

  // R3
  a_r3_count_restart: assert property (@(posedge clk) disable iff (rst || !armed)
    word_valid |-> cnt == '0);

  // R6 and R7
  a_r6_seed_take: assert property (@(posedge clk) disable iff (rst || !armed)
    seed_load |=> (cnt == '0) && !word_valid &&
      (state == (($past(seed_val) == '0) ? WIDTH'(1) : $past(seed_val))));

  // R4
  a_r4_word_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !word_valid |-> $stable(word_out));
endmodule

bind rng_word_gen rng_word_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .seed_load(seed_load), .seed_val(seed_val),
  .state(lfsr_q), .cnt(step_cnt), .word_out(word_out), .word_valid(word_valid)
);

// File: tb/sim_rng_word_gen.sv
module sim_rng_word_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        seed_load = 1'b0;
  logic [63:0] seed_val = '0;
  logic [63:0] word_out;
  logic        word_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] ref_st;
  int          ref_cnt;
  logic [63:0] exp_word;

  always #4 clk = ~clk;

  rng_word_gen u0 (
    .clk(clk), .rst(rst), .en(en), .seed_load(seed_load), .seed_val(seed_val),
    .word_out(word_out), .word_valid(word_valid)
  );

  // Reference step: shift toward MSB, new bit 0 = b63^b62^b60^b59 (R2)
  function automatic logic [63:0] ref_next(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, predict, sample just after posedge
  task automatic cyc(input bit en_i, input bit ld_i, input logic [63:0] sd,
                     input string tag);
    bit exp_v = 1'b0;
    @(negedge clk);
    en = en_i; seed_load = ld_i; seed_val = sd;
    if (ld_i) begin
      ref_st  = (sd == 64'd0) ? 64'd1 : sd;
      ref_cnt = 0;
    end else if (en_i) begin
      ref_st = ref_next(ref_st);
      if (ref_cnt == 63) begin
        ref_cnt = 0; exp_v = 1'b1; exp_word = ref_st;
      end else begin
        ref_cnt++;
      end
    end
    @(posedge clk); #1;
    check(word_valid == exp_v, {tag, " valid"}, 64'(word_valid), 64'(exp_v));
    check(word_out == exp_word, {tag, " word"}, word_out, exp_word);
    if (exp_v) check(word_out != 64'd0, "R8 nonzero word", word_out, exp_word);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; seed_load = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(word_valid == 1'b0, "R1 valid in reset", 64'(word_valid), 64'd0);
    check(word_out == 64'd0, "R1 word in reset", word_out, 64'd0);
    @(negedge clk); rst = 1'b0; en = 1'b0;
    ref_st = 64'd1; ref_cnt = 0; exp_word = 64'd0;
  endtask

  task automatic t_first_word();
    logic [63:0] w = 64'd1;
    for (int i = 0; i < 64; i++) w = ref_next(w);
    for (int i = 0; i < 64; i++) cyc(1'b1, 1'b0, '0, "R3 first word");
    check(word_out == w, "R1 seed one gives first word", word_out, w);
  endtask

  task automatic t_free_run();
    for (int i = 0; i < 3 * 64; i++) cyc(1'b1, 1'b0, '0, "R4 free run");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 200; i++) cyc((i % 3) != 0, 1'b0, '0, "R5 gapped enable");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 100; i++) cyc(1'b0, 1'b0, '0, "R5 idle hold");
    for (int i = 0; i < 80; i++) cyc(1'b1, 1'b0, '0, "R5 resume");
  endtask

  task automatic t_seed();
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, '0, "R6 before load");
    cyc(1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, "R6 load with en");
    for (int i = 0; i < 70; i++) cyc(1'b1, 1'b0, '0, "R6 after load");
  endtask

  task automatic t_zero_seed();
    logic [63:0] w = 64'd1;
    for (int i = 0; i < 64; i++) w = ref_next(w);
    cyc(1'b0, 1'b1, 64'd0, "R7 zero seed");
    for (int i = 0; i < 64; i++) cyc(1'b1, 1'b0, '0, "R7 run");
    check(word_out == w, "R7 zero seed acts as one", word_out, w);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_word();
    t_free_run();
    t_gaps();
    t_idle();
    t_seed();
    t_zero_seed();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule